// File: doc/BRIEF.md
# Two-Port Serial Keyboard/Mouse Receiver with Cross-Inhibit

This block takes in frames from two PS/2 devices, a keyboard on port 0 and a mouse on port 1. Each device drives its own clock. All four wires are open-collector. The block never drives a data line. Its only output to the wires is a "hold this clock low" request for each port, which a pad turns into a pull-down. Both lines of each port are sampled on the fast system clock. Each line passes through a two-stage synchronizer and a glitch filter. Only after that are edges detected.

When a start bit shows up on an idle port, the block at once pulls the clock of the other port low, so that only one device can talk. It then shifts in the eleven-bit frame. After the last bit it holds both clocks low until the host takes the byte with a one-cycle read strobe. The host sees the byte, which port it came from, a valid flag and an error flag.

The keyboard clock is held low after reset until the first read strobe. While `mouse_en_i` is low, the mouse port is inhibited.

Top module: `ps2_dual_rx`

## Requirements
- R1: While reset is asserted and just after it, `kb_clk_low_o`=1, `ms_clk_low_o`=1 and `rx_valid_o`=0.
- R2: A keyboard frame (start 0, eight data bits LSB first, odd parity, stop 1) sets `rx_valid_o`=1 with `rx_port_o`=0, the byte on `rx_byte_o` and `rx_err_o`=0.
- R3: A mouse frame, accepted only while `mouse_en_i`=1, is reported with `rx_port_o`=1.
- R4: Once a start bit (data falls while clock is high) is seen on one idle port, the clock of the other port is held low until the host reads the byte.
- R5: While `rx_valid_o`=1, both clock-low outputs are 1.
- R6: A one-cycle `rd_i` while valid clears `rx_valid_o` on the next edge and releases the clocks. `rd_i` has no effect when the block is idle.
- R7: While valid and unread, `rx_byte_o`, `rx_port_o` and `rx_err_o` hold steady.
- R8: If the data bits and the parity bit together hold an even number of ones, the byte is delivered with `rx_err_o`=1.
- R9: A stop bit read as 0 is delivered with `rx_err_o`=1.
- R10: If the active clock line shows no edge for more than `TMO_CYCLES` system cycles mid-frame, the frame is dropped, nothing is reported and both ports return to idle. A later frame is received normally.
- R11: A pulse on any line that is shorter than `FILT_LEN` system cycles is ignored.
- R12: While `mouse_en_i`=0, `ms_clk_low_o`=1 and mouse start bits are ignored (the keyboard clock is not inhibited).
- R13: After reset, the first `rd_i` releases the keyboard clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the device clock |
| rst_n | input | 1 | Active-low reset: asserted asynchronously, released in step with clk |
| mouse_en_i | input | 1 | 1 enables port 1 (mouse) |
| kb_clk_i | input | 1 | Keyboard clock line as read at the pad |
| kb_dat_i | input | 1 | Keyboard data line as read at the pad |
| ms_clk_i | input | 1 | Mouse clock line as read at the pad |
| ms_dat_i | input | 1 | Mouse data line as read at the pad |
| rd_i | input | 1 | Host read strobe, one cycle |
| kb_clk_low_o | output | 1 | 1 pulls the keyboard clock low |
| ms_clk_low_o | output | 1 | 1 pulls the mouse clock low |
| rx_byte_o | output | 8 | Received data byte |
| rx_port_o | output | 1 | Source port: 0 keyboard, 1 mouse |
| rx_valid_o | output | 1 | Byte waiting for the host |
| rx_err_o | output | 1 | Parity or stop-bit fault in the held frame |

## Verification
An input edge reaches the control state through two synchronizer flops, `FILT_LEN` filter cycles and one edge register. A frame result therefore shows up about `FILT_LEN`+4 system cycles after the eleventh falling clock edge. The inhibit on the other port shows up the same number of cycles after the start bit. The bench device model holds every line phase for 20 system cycles, well beyond that delay, and samples on the falling system-clock edge only once a phase has ended. A read strobe is driven for one cycle, and its effect is checked one cycle later. The timeout is checked after a wait of more than twice `TMO_CYCLES`.

// File: rtl/ps2_rx_pkg.sv
package ps2_rx_pkg;
  typedef enum logic [1:0] {
    ST_INIT = 2'd0,
    ST_IDLE = 2'd1,
    ST_RECV = 2'd2,
    ST_FULL = 2'd3
  } arb_st_t;

  localparam int FRAME_BITS = 11;

  // frame[0]=start, [8:1]=data LSB first, [9]=odd parity, [10]=stop
  function automatic logic frame_bad(input logic [FRAME_BITS-1:0] f);
    return f[0] | ~f[FRAME_BITS-1] | ~(^f[9:1]);
  endfunction
endpackage

// File: rtl/ps2_line_filter.sv
module ps2_line_filter #(
  parameter int FILT_LEN = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic raw_i,
  output logic clean_o
);
  localparam int CW = $clog2(FILT_LEN + 1);

  logic          meta_q, sync_q;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          out_q, out_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b1;
      sync_q <= 1'b1;
    end else begin
      meta_q <= raw_i;
      sync_q <= meta_q;
    end
  end

  always_comb begin
    cnt_d = '0;
    out_d = out_q;
    if (sync_q != out_q) begin
      if (cnt_q == CW'(FILT_LEN - 1)) begin
        out_d = sync_q;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      out_q <= 1'b1;
    end else begin
      cnt_q <= cnt_d;
      out_q <= out_d;
    end
  end

  assign clean_o = out_q;

  // R11: the filtered level only ever moves to a value the synchronizer held
  a_r11_filter_follow: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(out_q) |-> out_q == $past(sync_q));
endmodule

// File: rtl/ps2_frame_shift.sv
module ps2_frame_shift
  import ps2_rx_pkg::*;
#(
  parameter int TMO_CYCLES = 100000
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  run_i,
  input  logic                  fall_i,
  input  logic                  edge_i,
  input  logic                  dat_i,
  output logic                  done_o,
  output logic                  tmo_o,
  output logic [FRAME_BITS-1:0] frame_o
);
  localparam int BW = $clog2(FRAME_BITS + 1);
  localparam int TW = $clog2(TMO_CYCLES + 2);

  logic [FRAME_BITS-1:0] sh_q, sh_d;
  logic [BW-1:0]         cnt_q, cnt_d;
  logic [TW-1:0]         idle_q, idle_d;
  logic                  last_bit;

  assign last_bit = (cnt_q == BW'(FRAME_BITS - 1));

  always_comb begin
    sh_d   = sh_q;
    cnt_d  = cnt_q;
    idle_d = idle_q;
    if (!run_i) begin
      cnt_d  = '0;
      idle_d = '0;
    end else begin
      if (fall_i) begin
        sh_d  = {dat_i, sh_q[FRAME_BITS-1:1]};
        cnt_d = last_bit ? '0 : cnt_q + 1'b1;
      end
      if (edge_i) begin
        idle_d = '0;
      end else if (idle_q != TW'(TMO_CYCLES)) begin
        idle_d = idle_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q   <= '0;
      cnt_q  <= '0;
      idle_q <= '0;
    end else begin
      sh_q   <= sh_d;
      cnt_q  <= cnt_d;
      idle_q <= idle_d;
    end
  end

  assign done_o  = run_i & fall_i & last_bit;
  assign tmo_o   = run_i & (idle_q == TW'(TMO_CYCLES));
  assign frame_o = {dat_i, sh_q[FRAME_BITS-1:1]};

  // R2: the bit counter never passes the frame length
  a_r2_bitcnt_range: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q < BW'(FRAME_BITS));
  // R10: the idle counter restarts whenever the receiver is parked
  a_r10_idle_clear: assert property (@(posedge clk) disable iff (!rst_n)
    !run_i |=> idle_q == '0);
endmodule

// File: rtl/ps2_dual_rx.sv
module ps2_dual_rx
  import ps2_rx_pkg::*;
#(
  parameter int FILT_LEN   = 8,
  parameter int TMO_CYCLES = 100000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       mouse_en_i,
  input  logic       kb_clk_i,
  input  logic       kb_dat_i,
  input  logic       ms_clk_i,
  input  logic       ms_dat_i,
  input  logic       rd_i,
  output logic       kb_clk_low_o,
  output logic       ms_clk_low_o,
  output logic [7:0] rx_byte_o,
  output logic       rx_port_o,
  output logic       rx_valid_o,
  output logic       rx_err_o
);
  localparam int NPORT  = 2;
  localparam int NLINE  = 2 * NPORT;

  logic [NLINE-1:0] raw_w, clean_w;
  logic [NLINE-1:0] prev_q;
  logic [NPORT-1:0] clk_f, dat_f, clk_fall, clk_edge, dat_fall, port_ok;

  // line order: {ms_dat, ms_clk, kb_dat, kb_clk}
  assign raw_w = {ms_dat_i, ms_clk_i, kb_dat_i, kb_clk_i};

  for (genvar i = 0; i < NLINE; i++) begin : g_line
    ps2_line_filter #(.FILT_LEN(FILT_LEN)) u_filt (
      .clk    (clk),
      .rst_n  (rst_n),
      .raw_i  (raw_w[i]),
      .clean_o(clean_w[i])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '1;
    else        prev_q <= clean_w;
  end

  for (genvar p = 0; p < NPORT; p++) begin : g_port
    assign clk_f[p]    = clean_w[2*p];
    assign dat_f[p]    = clean_w[2*p+1];
    assign clk_fall[p] = prev_q[2*p] & ~clean_w[2*p];
    assign clk_edge[p] = prev_q[2*p] ^ clean_w[2*p];
    assign dat_fall[p] = prev_q[2*p+1] & ~clean_w[2*p+1] & clk_f[p];
  end

  assign port_ok = {mouse_en_i, 1'b1};

  arb_st_t               st_q, st_d;
  logic                  act_q, act_d;
  logic                  run_w, done_w, tmo_w;
  logic [FRAME_BITS-1:0] frame_w;
  logic                  cap_en;
  logic [7:0]            byte_q;
  logic                  port_q, err_q;

  assign run_w = (st_q == ST_RECV);

  ps2_frame_shift #(.TMO_CYCLES(TMO_CYCLES)) u_shift (
    .clk    (clk),
    .rst_n  (rst_n),
    .run_i  (run_w),
    .fall_i (clk_fall[act_q]),
    .edge_i (clk_edge[act_q]),
    .dat_i  (dat_f[act_q]),
    .done_o (done_w),
    .tmo_o  (tmo_w),
    .frame_o(frame_w)
  );

  always_comb begin
    st_d   = st_q;
    act_d  = act_q;
    cap_en = 1'b0;
    unique case (st_q)
      ST_INIT: if (rd_i) st_d = ST_IDLE;
      ST_IDLE: begin
        if (dat_fall[0] && port_ok[0]) begin
          st_d  = ST_RECV;
          act_d = 1'b0;
        end else if (dat_fall[1] && port_ok[1]) begin
          st_d  = ST_RECV;
          act_d = 1'b1;
        end
      end
      ST_RECV: begin
        if (done_w) begin
          st_d   = ST_FULL;
          cap_en = 1'b1;
        end else if (tmo_w) begin
          st_d = ST_IDLE;
        end
      end
      ST_FULL: if (rd_i) st_d = ST_IDLE;
      default: st_d = ST_INIT;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_INIT;
      act_q <= 1'b0;
    end else begin
      st_q  <= st_d;
      act_q <= act_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      byte_q <= '0;
      port_q <= 1'b0;
      err_q  <= 1'b0;
    end else if (cap_en) begin
      byte_q <= frame_w[8:1];
      port_q <= act_q;
      err_q  <= frame_bad(frame_w);
    end
  end

  logic kb_hold, ms_hold;
  always_comb begin
    kb_hold = 1'b1;
    ms_hold = 1'b1;
    unique case (st_q)
      ST_IDLE: begin
        kb_hold = 1'b0;
        ms_hold = ~mouse_en_i;
      end
      ST_RECV: begin
        kb_hold = act_q;
        ms_hold = ~act_q;
      end
      default: begin
        kb_hold = 1'b1;
        ms_hold = 1'b1;
      end
    endcase
  end

  assign kb_clk_low_o = kb_hold;
  assign ms_clk_low_o = ms_hold;
  assign rx_byte_o    = byte_q;
  assign rx_port_o    = port_q;
  assign rx_err_o     = err_q;
  assign rx_valid_o   = (st_q == ST_FULL);

  // R4: during reception at most one clock is released
  a_r4_single_talker: assert property (@(posedge clk) disable iff (!rst_n)
    run_w |-> $countones({~kb_clk_low_o, ~ms_clk_low_o}) <= 1);
  // R5: a pending byte throttles both devices
  a_r5_hold_both: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid_o |-> kb_clk_low_o && ms_clk_low_o);
  // R6: a read of a pending byte retires it on the next edge
  a_r6_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid_o && rd_i |=> !rx_valid_o);
  // R7: an unread result holds still
  a_r7_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid_o && !rd_i |=> rx_valid_o && $stable(rx_byte_o) && $stable(rx_port_o) && $stable(rx_err_o));
  // R10: an abort never produces a result
  a_r10_abort_silent: assert property (@(posedge clk) disable iff (!rst_n)
    run_w && tmo_w && !done_w |=> !rx_valid_o);
  // R12: a disabled mouse port is always inhibited
  a_r12_mouse_off: assert property (@(posedge clk) disable iff (!rst_n)
    !mouse_en_i |-> ms_clk_low_o);
endmodule

// File: tb/test_ps2_dual_rx.sv
module test_ps2_dual_rx;
  localparam int CLK_PERIOD = 10;
  localparam int HP   = 20;
  localparam int FILT = 4;
  localparam int TMO  = 300;

  logic clk, rst_n, mouse_en, rd;
  logic kb_dc, kb_dd, ms_dc, ms_dd;
  logic kb_low, ms_low;
  logic [7:0] rx_byte;
  logic rx_port, rx_valid, rx_err;
  logic kb_c, kb_d, ms_c, ms_d;

  assign kb_c = kb_dc & ~kb_low;
  assign ms_c = ms_dc & ~ms_low;
  assign kb_d = kb_dd;
  assign ms_d = ms_dd;

  int total = 0;
  int bad   = 0;

  ps2_dual_rx #(.FILT_LEN(FILT), .TMO_CYCLES(TMO)) i_ps2_dual_rx (
    .clk(clk), .rst_n(rst_n), .mouse_en_i(mouse_en),
    .kb_clk_i(kb_c), .kb_dat_i(kb_d), .ms_clk_i(ms_c), .ms_dat_i(ms_d),
    .rd_i(rd), .kb_clk_low_o(kb_low), .ms_clk_low_o(ms_low),
    .rx_byte_o(rx_byte), .rx_port_o(rx_port), .rx_valid_o(rx_valid), .rx_err_o(rx_err)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cycles(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic read_pulse();
    @(negedge clk);
    rd = 1'b1;
    @(negedge clk);
    rd = 1'b0;
  endtask

  // device model: nbits of frame, other-port inhibit sampled after start bit
  task automatic dev_frame(input logic port, input logic [7:0] b, input logic flip,
                           input logic stopv, input int nbits, output logic inhib);
    logic [10:0] f;
    f = {stopv, (~^b) ^ flip, b, 1'b0};
    inhib = 1'b0;
    for (int i = 0; i < nbits; i++) begin
      if (port) ms_dd = f[i]; else kb_dd = f[i];
      cycles(HP);
      if (i == 0) inhib = port ? kb_low : ms_low;
      if (port) ms_dc = 1'b0; else kb_dc = 1'b0;
      cycles(HP);
      if (port) ms_dc = 1'b1; else kb_dc = 1'b1;
    end
    if (port) ms_dd = 1'b1; else kb_dd = 1'b1;
    cycles(HP);
  endtask

  // {port, byte, flip parity, stop value, expected error}
  localparam logic [11:0] VEC [6] = '{
    {1'b0, 8'hA5, 1'b0, 1'b1, 1'b0},
    {1'b0, 8'h00, 1'b0, 1'b1, 1'b0},
    {1'b1, 8'hFF, 1'b0, 1'b1, 1'b0},
    {1'b1, 8'h3C, 1'b1, 1'b1, 1'b1},
    {1'b0, 8'h81, 1'b0, 1'b0, 1'b1},
    {1'b1, 8'h01, 1'b1, 1'b0, 1'b1}
  };

  initial begin
    repeat (150000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic inh;
    rst_n = 1'b0; mouse_en = 1'b0; rd = 1'b0;
    kb_dc = 1'b1; kb_dd = 1'b1; ms_dc = 1'b1; ms_dd = 1'b1;
    cycles(3);
    check("R1 kb held", 16'(kb_low), 16'd1);
    check("R1 ms held", 16'(ms_low), 16'd1);
    check("R1 valid",   16'(rx_valid), 16'd0);
    @(negedge clk) rst_n = 1'b1;
    cycles(2);
    check("R1 kb held after reset", 16'(kb_low), 16'd1);

    read_pulse();
    cycles(1);
    check("R13 kb released", 16'(kb_low), 16'd0);
    check("R12 ms held while disabled", 16'(ms_low), 16'd1);

    ms_dd = 1'b0;
    cycles(60);
    check("R12 mouse start ignored", 16'(kb_low), 16'd0);
    ms_dd = 1'b1;
    cycles(20);

    mouse_en = 1'b1;
    cycles(3);
    check("R12 ms released when enabled", 16'(ms_low), 16'd0);

    read_pulse();
    cycles(3);
    check("R6 read in idle valid", 16'(rx_valid), 16'd0);
    check("R6 read in idle clocks", 16'({kb_low, ms_low}), 16'd0);

    @(negedge clk) kb_dd = 1'b0;
    @(negedge clk);
    @(negedge clk) kb_dd = 1'b1;
    cycles(30);
    check("R11 glitch ignored", 16'(ms_low), 16'd0);

    for (int v = 0; v < 6; v++) begin
      logic [11:0] e;
      e = VEC[v];
      dev_frame(e[11], e[10:3], e[2], e[1], 11, inh);
      check("R4 other port inhibited", 16'(inh), 16'd1);
      check(e[11] ? "R3 valid" : "R2 valid", 16'(rx_valid), 16'd1);
      check(e[11] ? "R3 port" : "R2 port", 16'(rx_port), 16'(e[11]));
      check("R2 byte", 16'(rx_byte), 16'(e[10:3]));
      check(e[1] ? "R8 error flag" : "R9 error flag", 16'(rx_err), 16'(e[0]));
      check("R5 both held", 16'({kb_low, ms_low}), 16'h3);
      cycles(50);
      check("R7 held byte", 16'({rx_valid, rx_port, rx_byte}), 16'({1'b1, e[11], e[10:3]}));
      read_pulse();
      check("R6 valid cleared", 16'(rx_valid), 16'd0);
      cycles(1);
      check("R6 clocks released", 16'({kb_low, ms_low}), 16'd0);
      cycles(10);
    end

    dev_frame(1'b0, 8'h55, 1'b0, 1'b1, 4, inh);
    check("R4 inhibit in partial frame", 16'(inh), 16'd1);
    cycles(2 * TMO + 40);
    check("R10 abort no valid", 16'(rx_valid), 16'd0);
    check("R10 back to idle", 16'({kb_low, ms_low}), 16'd0);
    dev_frame(1'b1, 8'h6B, 1'b0, 1'b1, 11, inh);
    check("R10 frame after abort", 16'({rx_valid, rx_port, rx_err, rx_byte}),
          16'({1'b1, 1'b1, 1'b0, 8'h6B}));
    read_pulse();

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule